// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Input Interface

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A single 12-bit parallel bus feeds both channels. An active-low write strobe, together with a channel-select line, steers a full word into one channel's staging register. The staging works like a RAM write cycle. An active-low load strobe then copies both staging registers into the two conversion registers in the same cycle, so both analog outputs change together. The block presents the two conversion register values on its outputs.

The model is synchronous. Each strobe acts as a level-sensitive enable that is sampled on the system clock. While an enable is active, its register follows its source on every clock. When the enable goes inactive, the register keeps the last value it took. If both strobes are held low, the bus passes through to the selected channel's output one clock later.

A strobe timing monitor counts, in clock cycles, how long the controls and data were held before the end of each strobe. It raises a one-cycle flag whenever a minimum pulse width or setup time is not met.

Top module: `dacif_top`

## Requirements
- R1: Synchronous reset clears both staging registers, both conversion registers and every timing flag to zero.
- R2: When write is sampled low with `sel_a` = 1, the channel A staging register takes the bus word at that clock edge. The channel B staging register is left unchanged.
- R3: When write is sampled low with `sel_a` = 0, the channel B staging register takes the bus word at that clock edge. The channel A staging register is left unchanged.
- R4: After write returns high, the staging register keeps the last word captured while write was low. Later changes on the bus have no effect on it.
- R5: When load is sampled low, both conversion registers take their staging register values at the same clock edge. This includes a word written in that same cycle.
- R6: While load is sampled high, neither conversion output changes, even while staging registers are being written.
- R7: With write and load both low, the bus word reaches the selected channel's output one clock later. Changing `sel_a` in the middle of the write moves this pass-through to the other channel.
- R8: `tmg_viol[0]` pulses for one cycle after the edge at which write is first sampled high, if the preceding low run was shorter than `WR_PW_MIN` samples.
- R9: `tmg_viol[1]` pulses for one cycle after the edge at which load is first sampled high, if the preceding low run was shorter than `LD_PW_MIN` samples.
- R10: `tmg_viol[2]` pulses at the end of a write if `sel_a` held its final level for fewer than `SEL_SU_MIN` samples up to the last low write sample.
- R11: `tmg_viol[3]` pulses at the end of a write if the bus held its final word for fewer than `DAT_SU_MIN` samples up to the last low write sample.
- R12: `tmg_viol[4]` pulses at the end of a write if load held its final level for fewer than `LD_SU_MIN` samples up to the last low write sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 12 | Shared parallel data word |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe for both channels, active low |
| sel_a | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| out_a | output | 12 | Channel A conversion register |
| out_b | output | 12 | Channel B conversion register |
| tmg_viol | output | 5 | One-cycle timing flags: [0] write width, [1] load width, [2] select setup, [3] data setup, [4] load-to-write setup |

## Verification
A corrupted staging register cannot be seen at the outputs until load is next taken low. At that point it appears on `out_a` or `out_b` one clock after the load sample. The stimulus therefore follows each write with a load, so that staging faults become visible. Errors in a conversion register show up on the very next clock. A miscounted setup or width run shows up as a flag that is missing or stray, in the cycle after the edge at which the strobe is first sampled high.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int DW       = 12;
    localparam int NUM_CH   = 2;
    localparam int NUM_VIOL = 5;

    typedef enum int {
        V_WR_PW  = 0,
        V_LD_PW  = 1,
        V_SEL_SU = 2,
        V_DAT_SU = 3,
        V_LD_SU  = 4
    } viol_idx_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacif_run_len.sv
module dacif_run_len #(
    parameter int            SW      = 1,
    parameter int            CW      = 4,
    parameter logic [SW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sig,
    output logic [SW-1:0] prev,
    output logic [CW-1:0] run
);

    // run = number of consecutive samples equal to the latest sample
    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= RST_VAL;
            run  <= '0;
        end else begin
            prev <= sig;
            if (sig != prev)
                run <= CW'(1);
            else if (run != '1)
                run <= run + CW'(1);
        end
    end

endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
    parameter int DW = dacif_pkg::DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          ld_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] conv_q
);

    logic [DW-1:0] stage_q;
    logic [DW-1:0] stage_nxt;

    // staging register is transparent while enabled; the conversion
    // register sees the staging register's value after this edge
    always_comb stage_nxt = wr_en ? din : stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            conv_q  <= '0;
        end else begin
            stage_q <= stage_nxt;
            if (ld_en)
                conv_q <= stage_nxt;
        end
    end

endmodule

// File: rtl/dacif_timing_mon.sv
module dacif_timing_mon
    import dacif_pkg::*;
#(
    parameter int DW         = dacif_pkg::DW,
    parameter int WR_PW_MIN  = 7,
    parameter int LD_PW_MIN  = 5,
    parameter int SEL_SU_MIN = 8,
    parameter int DAT_SU_MIN = 7,
    parameter int LD_SU_MIN  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_n,
    input  logic                ld_n,
    input  logic                sel_a,
    input  logic [DW-1:0]       data,
    output logic [NUM_VIOL-1:0] viol
);

    localparam int CMAX = max_of(max_of(WR_PW_MIN, LD_PW_MIN),
                                 max_of(SEL_SU_MIN, max_of(DAT_SU_MIN, LD_SU_MIN)));
    localparam int CW   = $clog2(CMAX + 1);

    logic          wr_q, ld_q, sel_q;
    logic [DW-1:0] dat_q;
    logic [CW-1:0] wr_run, ld_run, sel_run, dat_run;
    logic          wr_rise, ld_rise;
    logic [NUM_VIOL-1:0] viol_nxt;

    dacif_run_len #(.SW(1), .CW(CW), .RST_VAL(1'b1)) u_wr_run (
        .clk(clk), .rst(rst), .sig(wr_n), .prev(wr_q), .run(wr_run));
    dacif_run_len #(.SW(1), .CW(CW), .RST_VAL(1'b1)) u_ld_run (
        .clk(clk), .rst(rst), .sig(ld_n), .prev(ld_q), .run(ld_run));
    dacif_run_len #(.SW(1), .CW(CW), .RST_VAL(1'b0)) u_sel_run (
        .clk(clk), .rst(rst), .sig(sel_a), .prev(sel_q), .run(sel_run));
    dacif_run_len #(.SW(DW), .CW(CW), .RST_VAL('0)) u_dat_run (
        .clk(clk), .rst(rst), .sig(data), .prev(dat_q), .run(dat_run));

    always_comb begin
        wr_rise = !wr_q && wr_n;
        ld_rise = !ld_q && ld_n;
        viol_nxt           = '0;
        viol_nxt[V_WR_PW]  = wr_rise && (wr_run  < CW'(WR_PW_MIN));
        viol_nxt[V_LD_PW]  = ld_rise && (ld_run  < CW'(LD_PW_MIN));
        viol_nxt[V_SEL_SU] = wr_rise && (sel_run < CW'(SEL_SU_MIN));
        viol_nxt[V_DAT_SU] = wr_rise && (dat_run < CW'(DAT_SU_MIN));
        viol_nxt[V_LD_SU]  = wr_rise && (ld_run  < CW'(LD_SU_MIN));
    end

    always_ff @(posedge clk) begin
        if (rst) viol <= '0;
        else     viol <= viol_nxt;
    end

    // previous-sample levels of select and data feed only the run counters
    logic unused_prev;
    always_comb unused_prev = sel_q ^ (^dat_q);

endmodule

// File: rtl/dacif_top.sv
module dacif_top
    import dacif_pkg::*;
#(
    parameter int DATA_W     = dacif_pkg::DW,
    parameter int WR_PW_MIN  = 7,
    parameter int LD_PW_MIN  = 5,
    parameter int SEL_SU_MIN = 8,
    parameter int DAT_SU_MIN = 7,
    parameter int LD_SU_MIN  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic                wr_n,
    input  logic                ld_n,
    input  logic                sel_a,
    output logic [DATA_W-1:0]   out_a,
    output logic [DATA_W-1:0]   out_b,
    output logic [NUM_VIOL-1:0] tmg_viol
);

    logic [DATA_W-1:0] conv [NUM_CH];

    // channel 0 is A (select high), channel 1 is B (select low)
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic SEL_LVL = (c == 0);
        logic wr_en;
        always_comb wr_en = !wr_n && (sel_a == SEL_LVL);

        dacif_channel #(.DW(DATA_W)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .ld_en (!ld_n),
            .din   (bus_data),
            .conv_q(conv[c])
        );
    end

    always_comb begin
        out_a = conv[0];
        out_b = conv[1];
    end

    dacif_timing_mon #(
        .DW        (DATA_W),
        .WR_PW_MIN (WR_PW_MIN),
        .LD_PW_MIN (LD_PW_MIN),
        .SEL_SU_MIN(SEL_SU_MIN),
        .DAT_SU_MIN(DAT_SU_MIN),
        .LD_SU_MIN (LD_SU_MIN)
    ) u_tmon (
        .clk  (clk),
        .rst  (rst),
        .wr_n (wr_n),
        .ld_n (ld_n),
        .sel_a(sel_a),
        .data (bus_data),
        .viol (tmg_viol)
    );

endmodule

// File: rtl/dacif_sva.sv
module dacif_sva
    import dacif_pkg::*;
#(
    parameter int DATA_W = dacif_pkg::DW
) (
    input logic                clk,
    input logic                rst,
    input logic [DATA_W-1:0]   bus_data,
    input logic                wr_n,
    input logic                ld_n,
    input logic                sel_a,
    input logic [DATA_W-1:0]   out_a,
    input logic [DATA_W-1:0]   out_b,
    input logic [NUM_VIOL-1:0] tmg_viol
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_a == '0 && out_b == '0 && tmg_viol == '0));

    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> ($stable(out_a) && $stable(out_b)));

    p_flow_a_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !ld_n && sel_a) |=> (out_a == $past(bus_data)));

    p_flow_b_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !ld_n && !sel_a) |=> (out_b == $past(bus_data)));

    p_wr_width_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
        tmg_viol[V_WR_PW] |-> ($past(wr_n) && !$past(wr_n, 2)));

    p_ld_width_at_rise_r9: assert property (@(posedge clk) disable iff (rst)
        tmg_viol[V_LD_PW] |-> ($past(ld_n) && !$past(ld_n, 2)));

endmodule

bind dacif_top dacif_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/dacif_top_tb.sv
module dacif_top_tb;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] bus_data = '0;
    logic         wr_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         sel_a = 1'b0;
    logic [W-1:0] out_a, out_b;
    logic [4:0]   tmg_viol;

    always #10 clk = ~clk;

    dacif_top u_dut (
        .clk(clk), .rst(rst), .bus_data(bus_data), .wr_n(wr_n), .ld_n(ld_n),
        .sel_a(sel_a), .out_a(out_a), .out_b(out_b), .tmg_viol(tmg_viol));

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit started = 1'b0;

    // behavioural reference
    int ha, hb, ca, cb;
    int exp_viol [5];
    int wr_h[$], ld_h[$], sel_h[$], dat_h[$];
    string viol_req [5] = '{"R8", "R9", "R10", "R11", "R12"};

    function automatic int tail_run(int q[$]);
        int n = 0;
        if (q.size() == 0) return 0;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i] != q[q.size() - 1]) break;
            n++;
        end
        return n;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ha = 0; hb = 0; ca = 0; cb = 0;
            foreach (exp_viol[i]) exp_viol[i] = 0;
            wr_h.delete(); ld_h.delete(); sel_h.delete(); dat_h.delete();
        end else begin
            bit wrise, lrise;
            int na, nb;
            na = (!wr_n && sel_a)  ? int'(bus_data) : ha;
            nb = (!wr_n && !sel_a) ? int'(bus_data) : hb;
            if (!ld_n) begin ca = na; cb = nb; end
            ha = na; hb = nb;
            wrise = (wr_h.size() > 0) && (wr_h[$] == 0) && wr_n;
            lrise = (ld_h.size() > 0) && (ld_h[$] == 0) && ld_n;
            exp_viol[0] = int'(wrise && tail_run(wr_h)  < 7);
            exp_viol[1] = int'(lrise && tail_run(ld_h)  < 5);
            exp_viol[2] = int'(wrise && tail_run(sel_h) < 8);
            exp_viol[3] = int'(wrise && tail_run(dat_h) < 7);
            exp_viol[4] = int'(wrise && tail_run(ld_h)  < 4);
            wr_h.push_back(int'(wr_n));
            ld_h.push_back(int'(ld_n));
            sel_h.push_back(int'(sel_a));
            dat_h.push_back(int'(bus_data));
            if (wr_h.size()  > 16) void'(wr_h.pop_front());
            if (ld_h.size()  > 16) void'(ld_h.pop_front());
            if (sel_h.size() > 16) void'(sel_h.pop_front());
            if (dat_h.size() > 16) void'(dat_h.pop_front());
        end
        started = 1'b1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "out_a", int'(out_a), ca);
            chk(cur_req, "out_b", int'(out_b), cb);
            for (int i = 0; i < 5; i++)
                chk(viol_req[i], "tmg_viol bit", int'(tmg_viol[i]), exp_viol[i]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic s, input logic [W-1:0] d, input int pre, input int w);
        @(negedge clk);
        sel_a = s; bus_data = d; wr_n = 1'b1;
        repeat (pre) @(negedge clk);
        wr_n = 1'b0;
        repeat (w) @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic do_load(input int w);
        @(negedge clk);
        ld_n = 1'b0;
        repeat (w) @(negedge clk);
        ld_n = 1'b1;
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        rst = 1'b0;
        idle(3);

        cur_req = "R2";                      // write A, B untouched
        do_write(1'b1, 12'hABC, 2, 7); idle(3);
        do_load(5); idle(3);

        cur_req = "R3";                      // write B, A untouched
        do_write(1'b0, 12'h123, 2, 7); idle(3);
        do_load(5); idle(3);

        cur_req = "R4";                      // bus changes after write ignored
        do_write(1'b1, 12'h5A5, 2, 7);
        @(negedge clk); bus_data = 12'hFFF; idle(4);
        do_load(5); idle(3);

        cur_req = "R6";                      // write without load: outputs hold
        do_write(1'b1, 12'h777, 2, 7);
        do_write(1'b0, 12'h0F0, 2, 7); idle(4);

        cur_req = "R5";                      // simultaneous update of both
        do_load(5); idle(3);

        cur_req = "R7";                      // flow-through, select moves
        @(negedge clk); sel_a = 1'b1; ld_n = 1'b0; wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bus_data = W'(12'h100 + i * 17); @(negedge clk);
        end
        sel_a = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bus_data = W'(12'h800 + i * 33); @(negedge clk);
        end
        wr_n = 1'b1; ld_n = 1'b1; idle(12);

        cur_req = "R8";                      // short write pulse
        do_write(1'b0, 12'h321, 10, 3); idle(4);

        cur_req = "R9";                      // short load pulse
        do_load(2); idle(4);

        cur_req = "R10";                     // select changed late
        @(negedge clk); bus_data = 12'h456; idle(10);
        sel_a = 1'b1; wr_n = 1'b0; idle(7); wr_n = 1'b1; idle(4);

        cur_req = "R11";                     // data changed late
        @(negedge clk); bus_data = 12'h654; idle(10);
        wr_n = 1'b0; idle(5); bus_data = 12'h9C3; idle(2); wr_n = 1'b1; idle(4);

        cur_req = "R12";                     // load moved just before write end
        @(negedge clk); bus_data = 12'h2D2; idle(10);
        wr_n = 1'b0; idle(6); ld_n = 1'b0; idle(2); wr_n = 1'b1; idle(4);
        ld_n = 1'b1; idle(6);

        cur_req = "R1";                      // reset mid-run clears everything
        rst = 1'b1; idle(2); rst = 1'b0; idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule